// File: doc/BRIEF.md
# FIFO Interrupt Status Controller

This block derives the raw interrupt status of a peripheral bus interface that owns a write FIFO and a non-blocking read FIFO. Each cycle it compares the write FIFO's free-entry count and the read FIFO's valid-entry count against programmable trigger levels and registers one level flag per FIFO. It also watches three error causes: a full write FIFO, a stalled read, and a bus transaction held too long by the not-ready handshake. It latches each cause in its own sticky bit, which software clears by writing one to it.

The three-bit raw status word carries the write level flag, the read level flag and the OR of the error causes. A single interrupt line is the OR of that word. Masking lies downstream of the block. The block registers every output, so each one reflects the inputs sampled at the previous clock edge. The asynchronous active-low reset is released through a two-stage synchronizer, so the first update after release happens on the third rising edge.

Top module: `fifo_irq_status`

## Requirements
- R1: While reset is active and until the state registers leave reset, raw_status reads 3'b100, err_status reads 3'b000 and irq reads 1.
- R2: raw_status[2] is 1 one cycle after wr_free <= wr_trig is sampled, and 0 one cycle after wr_free > wr_trig is sampled.
- R3: raw_status[1] is 1 one cycle after rd_valid >= rd_trig is sampled, and 0 one cycle after rd_valid < rd_trig is sampled.
- R4: err_status[0] (write full) is set one cycle after wr_free == 0 is sampled with wfull_err_en high. A full FIFO with the enable low sets nothing.
- R5: err_status[1] (read stall) is set one cycle after rd_stall is sampled high with rstall_err_en high. A stall with the enable low sets nothing.
- R6: With max_wait nonzero, err_status[2] (timeout) is set one cycle after the (max_wait+1)-th consecutive cycle of xfer_not_ready. A max_wait of 0 never sets it.
- R7: The wait count restarts on any cycle with xfer_not_ready low or xfer_start high. Within one uninterrupted stall the timeout fires at most once, so clearing the bit mid-stall does not make it set again.
- R8: A cycle with err_clr_we high clears each err_status bit whose err_clr_mask bit is 1 and leaves bits with mask 0 unchanged. Mask bit positions match err_status.
- R9: If a cause's event and a clear of that cause are sampled in the same cycle, the bit is 1 afterwards.
- R10: raw_status[0] equals the OR of the three err_status bits. Bit 2 is the write flag and bit 1 is the read flag. Error clears never change bits 2 and 1.
- R11: irq equals the OR of the three raw_status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_free | input | WR_CNT_W | Free entries in the write FIFO |
| wr_trig | input | WR_CNT_W | Write trigger level |
| rd_valid | input | RD_CNT_W | Valid entries in the read FIFO |
| rd_trig | input | RD_CNT_W | Read trigger level |
| wfull_err_en | input | 1 | Enable for the write-full error cause |
| rstall_err_en | input | 1 | Enable for the read-stall error cause |
| rd_stall | input | 1 | Read-stall indication |
| xfer_not_ready | input | 1 | Not-ready handshake holding the current transaction |
| xfer_start | input | 1 | Start of a new transaction |
| max_wait | input | WAIT_W | Wait limit in cycles, 0 disables the timeout |
| err_clr_we | input | 1 | Write strobe for the error clear |
| err_clr_mask | input | 3 | Write-one-to-clear mask, bit 0 full, bit 1 stall, bit 2 timeout |
| raw_status | output | 3 | {write flag, read flag, error} |
| err_status | output | 3 | Per-cause sticky error bits |
| irq | output | 1 | OR of the raw status bits |

## Verification
The bench sweeps both occupancies across their trigger levels, including the equal case. An off-by-one comparison would then show a flag one count early or late. It holds not-ready for exactly max_wait and max_wait+1 cycles, and it breaks stalls with a ready cycle or a new transaction. A timer that counts one cycle short, never restarts, or fires again after a mid-stall clear would diverge from the reference on a specific cycle. It also raises events and their clears in the same cycle, where a design that let the clear win would drop a bit. A randomized phase then mixes all inputs and compares every output on every clock.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;
  localparam int NUM_CAUSES = 3;
  localparam int CAUSE_WFULL  = 0;
  localparam int CAUSE_RSTALL = 1;
  localparam int CAUSE_TMO    = 2;

  localparam int RAW_W       = 3;
  localparam int RAW_WR_BIT  = 2;
  localparam int RAW_RD_BIT  = 1;
  localparam int RAW_ERR_BIT = 0;

  typedef enum logic {
    LVL_AT_OR_BELOW = 1'b0,
    LVL_AT_OR_ABOVE = 1'b1
  } lvl_cmp_e;
endpackage

// File: rtl/fifo_lvl_flag.sv
module fifo_lvl_flag
  import fifo_irq_pkg::*;
#(
  parameter int       CNT_W   = 5,
  parameter lvl_cmp_e MODE    = LVL_AT_OR_BELOW,
  parameter logic     RST_VAL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] level,
  input  logic [CNT_W-1:0] trig,
  output logic             flag
);
  logic hit;
  logic flag_q;
  logic flag_en;

  generate
    if (MODE == LVL_AT_OR_BELOW) begin : g_below
      always_comb hit = (level <= trig);
    end else begin : g_above
      always_comb hit = (level >= trig);
    end
  endgenerate

  always_comb flag_en = (hit != flag_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= RST_VAL;
    end else if (flag_en) begin
      flag_q <= hit;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/wait_timer.sv
module wait_timer #(
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              not_ready,
  input  logic              txn_start,
  input  logic [WAIT_W-1:0] max_wait,
  output logic              timeout_ev
);
  localparam logic [WAIT_W-1:0] CNT_MAX = {WAIT_W{1'b1}};

  logic [WAIT_W-1:0] cnt_q, cnt_d;
  logic              fired_q, fired_d;
  logic              restart, armed, hit, cnt_en;

  always_comb begin
    restart = !not_ready || txn_start;
    armed   = (max_wait != '0);
    hit     = !restart && armed && !fired_q && (cnt_q == max_wait);
    cnt_d   = cnt_q;
    fired_d = fired_q;
    if (restart) begin
      cnt_d   = '0;
      fired_d = 1'b0;
    end else begin
      if (!fired_q && (cnt_q != CNT_MAX)) cnt_d = cnt_q + 1'b1;
      if (hit) fired_d = 1'b1;
    end
    cnt_en = (cnt_d != cnt_q) || (fired_d != fired_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q   <= cnt_d;
      fired_q <= fired_d;
    end
  end

  assign timeout_ev = hit;
endmodule

// File: rtl/err_cause_reg.sv
module err_cause_reg #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev,
  input  logic         clr_we,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] status
);
  logic [N-1:0] st_q;

  generate
    for (genvar i = 0; i < N; i++) begin : g_cause
      logic bit_d;
      logic bit_en;
      always_comb begin
        bit_d  = ev[i] | (st_q[i] & ~(clr_we & clr_mask[i]));
        bit_en = (bit_d != st_q[i]);
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          st_q[i] <= 1'b0;
        end else if (bit_en) begin
          st_q[i] <= bit_d;
        end
      end
    end
  endgenerate

  assign status = st_q;
endmodule

// File: rtl/fifo_irq_status.sv
module fifo_irq_status
  import fifo_irq_pkg::*;
#(
  parameter int WR_CNT_W = 5,
  parameter int RD_CNT_W = 5,
  parameter int WAIT_W   = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [WR_CNT_W-1:0]   wr_free,
  input  logic [WR_CNT_W-1:0]   wr_trig,
  input  logic [RD_CNT_W-1:0]   rd_valid,
  input  logic [RD_CNT_W-1:0]   rd_trig,
  input  logic                  wfull_err_en,
  input  logic                  rstall_err_en,
  input  logic                  rd_stall,
  input  logic                  xfer_not_ready,
  input  logic                  xfer_start,
  input  logic [WAIT_W-1:0]     max_wait,
  input  logic                  err_clr_we,
  input  logic [NUM_CAUSES-1:0] err_clr_mask,
  output logic [RAW_W-1:0]      raw_status,
  output logic [NUM_CAUSES-1:0] err_status,
  output logic                  irq
);
  logic [1:0]            rst_pipe_q;
  logic                  rst_sync_n;
  logic                  wr_flag, rd_flag, tmo_ev;
  logic [NUM_CAUSES-1:0] cause_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  fifo_lvl_flag #(.CNT_W(WR_CNT_W), .MODE(LVL_AT_OR_BELOW), .RST_VAL(1'b1)) u_wr_lvl (
    .clk(clk), .rst_n(rst_sync_n), .level(wr_free), .trig(wr_trig), .flag(wr_flag)
  );

  fifo_lvl_flag #(.CNT_W(RD_CNT_W), .MODE(LVL_AT_OR_ABOVE), .RST_VAL(1'b0)) u_rd_lvl (
    .clk(clk), .rst_n(rst_sync_n), .level(rd_valid), .trig(rd_trig), .flag(rd_flag)
  );

  wait_timer #(.WAIT_W(WAIT_W)) u_timer (
    .clk(clk), .rst_n(rst_sync_n), .not_ready(xfer_not_ready),
    .txn_start(xfer_start), .max_wait(max_wait), .timeout_ev(tmo_ev)
  );

  always_comb begin
    cause_ev               = '0;
    cause_ev[CAUSE_WFULL]  = wfull_err_en && (wr_free == '0);
    cause_ev[CAUSE_RSTALL] = rstall_err_en && rd_stall;
    cause_ev[CAUSE_TMO]    = tmo_ev;
  end

  err_cause_reg #(.N(NUM_CAUSES)) u_err (
    .clk(clk), .rst_n(rst_sync_n), .ev(cause_ev), .clr_we(err_clr_we),
    .clr_mask(err_clr_mask), .status(err_status)
  );

  always_comb begin
    raw_status              = '0;
    raw_status[RAW_WR_BIT]  = wr_flag;
    raw_status[RAW_RD_BIT]  = rd_flag;
    raw_status[RAW_ERR_BIT] = |err_status;
    irq                     = |raw_status;
  end
endmodule

// File: rtl/fifo_irq_status_chk.sv
module fifo_irq_status_chk #(
  parameter int WR_CNT_W = 5,
  parameter int RD_CNT_W = 5,
  parameter int WAIT_W   = 8
) (
  input logic                clk,
  input logic                rst_sync_n,
  input logic [WR_CNT_W-1:0] wr_free,
  input logic [WR_CNT_W-1:0] wr_trig,
  input logic [RD_CNT_W-1:0] rd_valid,
  input logic [RD_CNT_W-1:0] rd_trig,
  input logic                wfull_err_en,
  input logic                rstall_err_en,
  input logic                rd_stall,
  input logic [WAIT_W-1:0]   max_wait,
  input logic                err_clr_we,
  input logic [2:0]          err_clr_mask,
  input logic [2:0]          raw_status,
  input logic [2:0]          err_status
);
  p_wr_level_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_free <= wr_trig) |=> raw_status[2]);

  p_wr_clear_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_free > wr_trig) |=> !raw_status[2]);

  p_rd_level_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_valid >= rd_trig) |=> raw_status[1]);

  p_wfull_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wfull_err_en && wr_free == '0) |=> err_status[0]);

  p_stall_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rstall_err_en && rd_stall) |=> err_status[1]);

  p_zero_wait_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (max_wait == '0) |=> !$rose(err_status[2]));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (err_clr_we && err_clr_mask[1] && !(rstall_err_en && rd_stall)) |=> !err_status[1]);

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (err_status[2] && !(err_clr_we && err_clr_mask[2])) |=> err_status[2]);
endmodule

bind fifo_irq_status fifo_irq_status_chk #(
  .WR_CNT_W(WR_CNT_W), .RD_CNT_W(RD_CNT_W), .WAIT_W(WAIT_W)
) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .wr_free(wr_free), .wr_trig(wr_trig),
  .rd_valid(rd_valid), .rd_trig(rd_trig), .wfull_err_en(wfull_err_en),
  .rstall_err_en(rstall_err_en), .rd_stall(rd_stall), .max_wait(max_wait),
  .err_clr_we(err_clr_we), .err_clr_mask(err_clr_mask),
  .raw_status(raw_status), .err_status(err_status)
);

// File: tb/tb_fifo_irq_status.sv
module tb_fifo_irq_status;
  localparam int WR_CNT_W = 5;
  localparam int RD_CNT_W = 5;
  localparam int WAIT_W   = 8;

  logic                clk = 1'b0;
  logic                rst_n;
  logic [WR_CNT_W-1:0] wr_free, wr_trig;
  logic [RD_CNT_W-1:0] rd_valid, rd_trig;
  logic                wfull_err_en, rstall_err_en, rd_stall;
  logic                xfer_not_ready, xfer_start;
  logic [WAIT_W-1:0]   max_wait;
  logic                err_clr_we;
  logic [2:0]          err_clr_mask;
  logic [2:0]          raw_status, err_status;
  logic                irq;

  always #2 clk = ~clk;

  fifo_irq_status #(.WR_CNT_W(WR_CNT_W), .RD_CNT_W(RD_CNT_W), .WAIT_W(WAIT_W)) dut (
    .clk(clk), .rst_n(rst_n), .wr_free(wr_free), .wr_trig(wr_trig),
    .rd_valid(rd_valid), .rd_trig(rd_trig), .wfull_err_en(wfull_err_en),
    .rstall_err_en(rstall_err_en), .rd_stall(rd_stall),
    .xfer_not_ready(xfer_not_ready), .xfer_start(xfer_start), .max_wait(max_wait),
    .err_clr_we(err_clr_we), .err_clr_mask(err_clr_mask),
    .raw_status(raw_status), .err_status(err_status), .irq(irq)
  );

  // reference model state
  int n_vec = 0;
  int n_bad = 0;
  bit m_wr, m_rd;
  bit m_err [3];
  int m_held;
  bit m_fired;
  int m_rel;

  task automatic model_update();
    bit ev [3];
    if (!rst_n) begin
      m_wr = 1; m_rd = 0; m_err = '{0, 0, 0}; m_held = 0; m_fired = 0; m_rel = 0;
      return;
    end
    if (m_rel < 2) begin
      m_rel++;
      return;
    end
    ev[0] = wfull_err_en && (int'(wr_free) == 0);
    ev[1] = rstall_err_en && rd_stall;
    ev[2] = 0;
    if (!xfer_not_ready || xfer_start) begin
      m_held = 0; m_fired = 0;
    end else begin
      m_held++;
      if (int'(max_wait) != 0 && m_held == int'(max_wait) + 1 && !m_fired) begin
        ev[2] = 1; m_fired = 1;
      end
    end
    for (int i = 0; i < 3; i++)
      m_err[i] = ev[i] || (m_err[i] && !(err_clr_we && err_clr_mask[i]));
    m_wr = (int'(wr_free) <= int'(wr_trig));
    m_rd = (int'(rd_valid) >= int'(rd_trig));
  endtask

  task automatic compare(input string tag);
    logic [2:0] exp_err, exp_raw;
    logic       exp_irq;
    exp_err = {m_err[2], m_err[1], m_err[0]};
    exp_raw = {m_wr, m_rd, |exp_err};
    exp_irq = |exp_raw;
    n_vec++;
    if (raw_status !== exp_raw || err_status !== exp_err || irq !== exp_irq) begin
      n_bad++;
      $display("FAIL %s t=%0t raw=%b err=%b irq=%b expected raw=%b err=%b irq=%b",
               tag, $time, raw_status, err_status, irq, exp_raw, exp_err, exp_irq);
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model_update();
    #1 compare(tag);
    @(negedge clk);
  endtask

  task automatic quiet();
    wr_free = 5'd10; wr_trig = 5'd4; rd_valid = 5'd0; rd_trig = 5'd6;
    wfull_err_en = 0; rstall_err_en = 0; rd_stall = 0;
    xfer_not_ready = 0; xfer_start = 0; max_wait = '0;
    err_clr_we = 0; err_clr_mask = '0;
  endtask

  task automatic clear_all();
    err_clr_we = 1; err_clr_mask = 3'b111;
    step("R8 clear all");
    err_clr_we = 0; err_clr_mask = '0;
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog expired, actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0;
    quiet();
    wr_free = 5'd0; wfull_err_en = 1; rd_valid = 5'd20;
    @(negedge clk);
    for (int i = 0; i < 3; i++) step("R1 in reset");
    rst_n = 1;
    for (int i = 0; i < 2; i++) step("R1 sync release");
    quiet();
    step("R1 first update");

    // R2 write level sweep
    for (int t = 0; t < 3; t++) begin
      wr_trig = (t == 0) ? 5'd0 : (t == 1) ? 5'd4 : 5'd31;
      for (int f = 0; f < 32; f += 3) begin
        wr_free = 5'(f); wfull_err_en = 0;
        step("R2 write level");
      end
      wr_free = wr_trig; step("R2 equal");
      wr_free = wr_trig + 5'd1; step("R2 one above");
    end
    quiet();

    // R3 read level sweep
    for (int t = 0; t < 3; t++) begin
      rd_trig = (t == 0) ? 5'd0 : (t == 1) ? 5'd6 : 5'd31;
      for (int v = 0; v < 32; v += 3) begin
        rd_valid = 5'(v); step("R3 read level");
      end
      rd_valid = rd_trig; step("R3 equal");
      if (rd_trig != 0) begin rd_valid = rd_trig - 5'd1; step("R3 one below"); end
    end
    quiet();

    // R4 write full error
    wr_free = 5'd0; wfull_err_en = 0;
    for (int i = 0; i < 3; i++) step("R4 full disabled");
    wfull_err_en = 1; step("R4 full enabled");
    step("R4 held");
    err_clr_we = 1; err_clr_mask = 3'b001; step("R9 clear while full");
    wr_free = 5'd3; step("R8 clear after drain");
    err_clr_we = 0; step("R8 cleared");
    wr_free = 5'd0; step("R4 again");
    wr_free = 5'd3;
    err_clr_we = 1; err_clr_mask = 3'b110; step("R8 mask zero keeps bit");
    err_clr_mask = 3'b001; step("R10 clear keeps level bits");
    quiet();

    // R5 read stall error
    rd_stall = 1; rstall_err_en = 0; step("R5 stall disabled");
    rd_stall = 0; step("R5 no effect");
    rstall_err_en = 1; rd_stall = 1; step("R5 stall enabled");
    rd_stall = 0; step("R5 sticky");
    rd_stall = 1; err_clr_we = 1; err_clr_mask = 3'b010; step("R9 stall beats clear");
    rd_stall = 0; step("R8 stall cleared");
    quiet();

    // R6 timeout
    max_wait = '0; xfer_not_ready = 1;
    for (int i = 0; i < 20; i++) step("R6 zero wait disables");
    xfer_not_ready = 0; step("R7 ready");
    max_wait = 8'd5; xfer_not_ready = 1;
    for (int i = 0; i < 10; i++) step("R6 timeout 5");
    err_clr_we = 1; err_clr_mask = 3'b100; step("R7 clear mid stall");
    err_clr_we = 0;
    for (int i = 0; i < 10; i++) step("R7 no refire");
    xfer_not_ready = 0; step("R7 ready");
    max_wait = 8'd1; xfer_not_ready = 1;
    step("R6 limit 1 first"); step("R6 limit 1 second"); step("R6 limit 1 third");
    xfer_not_ready = 0; err_clr_we = 1; err_clr_mask = 3'b100; step("R8 clear tmo");
    err_clr_we = 0;
    max_wait = 8'd4;
    for (int k = 0; k < 4; k++) begin xfer_not_ready = 1; step("R7 exactly limit"); end
    xfer_not_ready = 0; step("R7 break");
    for (int k = 0; k < 3; k++) begin xfer_not_ready = 1; step("R7 partial"); end
    xfer_start = 1; step("R7 new transaction");
    xfer_start = 0;
    for (int k = 0; k < 4; k++) step("R7 restarted count");
    step("R6 fires after restart");
    step("R6 held");
    xfer_not_ready = 0; step("R6 ready");
    max_wait = 8'd2; xfer_not_ready = 1;
    step("R9 a"); step("R9 b");
    err_clr_we = 1; err_clr_mask = 3'b100; step("R9 tmo beats clear");
    err_clr_we = 0; step("R9 still set");
    quiet();
    clear_all();

    // randomized mix
    for (int i = 0; i < 600; i++) begin
      wr_free = 5'($urandom_range(0, 12)); wr_trig = 5'($urandom_range(0, 12));
      rd_valid = 5'($urandom_range(0, 12)); rd_trig = 5'($urandom_range(0, 12));
      wfull_err_en = 1'($urandom_range(0, 1)); rstall_err_en = 1'($urandom_range(0, 1));
      rd_stall = ($urandom_range(0, 9) == 0);
      xfer_not_ready = ($urandom_range(0, 7) != 0);
      xfer_start = ($urandom_range(0, 15) == 0);
      max_wait = 8'($urandom_range(0, 6));
      err_clr_we = ($urandom_range(0, 3) == 0);
      err_clr_mask = 3'($urandom_range(0, 7));
      step("R10 R11 random");
    end
    quiet();
    for (int i = 0; i < 3; i++) step("R11 idle");
    clear_all();
    step("R11 irq low");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule